// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block is a small translation lookaside buffer. It turns a 14-bit virtual address into a 12-bit physical address for a system with 64-byte pages. The virtual address has a 6-bit page offset and an 8-bit virtual page number. The physical address has a 6-bit physical page number followed by the same offset. The buffer holds sixteen translations in four sets of four ways. A lookup splits the virtual page number into a set index and a tag. It compares the tag against all four ways of the selected set in the same cycle, and reports either a hit with the physical address or a miss.

After a miss, the surrounding logic walks the page table elsewhere and then loads the result through the fill port. A fill goes into the first empty way of its set. If the set is full, a per-set round-robin pointer picks the way to replace. A fill whose tag already sits in the set only updates that entry. A flush input drops every translation, for example on an address-space switch.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, every lookup misses.
- R2: The set index is virtual address bits 7:6 (the low two bits of the virtual page number). The tag is virtual address bits 13:8. Fills use `fill_vpn[1:0]` as the set index and `fill_vpn[7:2]` as the tag.
- R3: A lookup hits when a valid entry in the selected set holds the lookup tag. The physical address is then that entry's 6-bit page number in bits 11:6, with virtual address bits 5:0 copied unchanged into bits 5:0.
- R4: Lookup is combinational. `lk_hit` and `lk_paddr` follow `lk_vaddr` in the same cycle, with no clock edge in between.
- R5: On a miss, `lk_hit` is 0 and `lk_paddr` is all zeros.
- R6: A fill takes effect at the next clock edge. In a set that still has an empty way, it writes the lowest-numbered empty way, so four fills with distinct tags into one set all stay resident.
- R7: A fill into a full set with a new tag replaces the way named by that set's 2-bit pointer. The pointer is 0 after reset and after a flush. It advances by one, wrapping from 3 to 0, on each such replacement and on nothing else.
- R8: A fill whose tag matches a valid entry of its set overwrites that entry's physical page number. It creates no duplicate, evicts no other entry and leaves the pointer unchanged.
- R9: A flush clears every valid bit and every replacement pointer at the next clock edge. When flush and fill are both asserted in the same cycle, the flush wins and the fill is dropped.
- R10: A fill into one set leaves the entries of the other sets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_vaddr | input | 14 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | 12 | Physical address on a hit, zero on a miss |
| fill_en | input | 1 | Load one translation at the next edge |
| fill_vpn | input | 8 | Virtual page number of the translation being loaded |
| fill_ppn | input | 6 | Physical page number of the translation being loaded |
| flush | input | 1 | Invalidate all translations at the next edge |

## Verification
The bench fills one set past its capacity several times. A wrong victim choice or a pointer that fails to advance would evict a different tag than the one the model predicts, and the next lookup of that tag would disagree. It also refills tags that are already resident. A design that writes a second copy would either push out a live neighbour or produce two matching ways and a corrupted address. Other directed cases cover a fill and a flush in the same cycle, and a fill into one set followed by lookups in the other sets. The random phase draws tags from a small pool so that hits, misses, overwrites and evictions all occur often, and every lookup is compared with a reference model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W   = 14;
    parameter int PA_W   = 12;
    parameter int OFF_W  = 6;
    parameter int WAYS   = 4;
    parameter int SETS   = 4;

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } entry_t;

    typedef struct packed {
        entry_t [SETS-1:0][WAYS-1:0] ent;
        logic   [SETS-1:0][WAY_W-1:0] ptr;
    } tlb_state_t;
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match
    import tlb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  entry_t [WAYS-1:0]      set_ents,
    input  logic   [TAG_W-1:0]     tag,
    output logic   [WAYS-1:0]      match,
    output logic                   hit,
    output logic   [PPN_W-1:0]     ppn
);
    // Compare the tag against every way of the set in parallel.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = set_ents[w].valid && (set_ents[w].tag == tag);
    end

    always_comb begin
        ppn = '0;
        for (int w = 0; w < WAYS; w++) begin
            ppn = ppn | (set_ents[w].ppn & {PPN_W{match[w]}});
        end
    end

    assign hit = |match;

    // R8: a set never holds the same tag twice.
    a_r8_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
    import tlb_pkg::*;
(
    input  logic [WAYS-1:0]  valid,
    input  logic [WAYS-1:0]  match,
    input  logic [WAY_W-1:0] ptr,
    output logic [WAY_W-1:0] way,
    output logic             replace
);
    logic             any_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] match_way;

    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    always_comb begin
        match_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) match_way = WAY_W'(w);
        end
    end

    always_comb begin
        replace = 1'b0;
        if (|match) begin
            way = match_way;
        end else if (any_free) begin
            way = free_way;
        end else begin
            way     = ptr;
            replace = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              flush
);
    tlb_state_t st_q, st_d;

    // Lookup path
    logic [IDX_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  lk_match;
    logic             lk_any;
    logic [PPN_W-1:0] lk_ppn;

    assign lk_set = lk_vaddr[OFF_W +: IDX_W];
    assign lk_tag = lk_vaddr[OFF_W + IDX_W +: TAG_W];

    tlb_way_match i_lk_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ents (st_q.ent[lk_set]),
        .tag      (lk_tag),
        .match    (lk_match),
        .hit      (lk_any),
        .ppn      (lk_ppn)
    );

    assign lk_hit   = lk_any;
    assign lk_paddr = lk_any ? {lk_ppn, lk_vaddr[OFF_W-1:0]} : '0;

    // Fill path
    logic [IDX_W-1:0] fl_set;
    logic [TAG_W-1:0] fl_tag;
    logic [WAYS-1:0]  fl_match;
    logic             fl_any;
    logic [PPN_W-1:0] fl_ppn_unused;
    logic [WAYS-1:0]  fl_valid;
    logic [WAY_W-1:0] fl_way;
    logic             fl_replace;

    assign fl_set = fill_vpn[IDX_W-1:0];
    assign fl_tag = fill_vpn[VPN_W-1:IDX_W];

    tlb_way_match i_fl_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ents (st_q.ent[fl_set]),
        .tag      (fl_tag),
        .match    (fl_match),
        .hit      (fl_any),
        .ppn      (fl_ppn_unused)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_valid
        assign fl_valid[w] = st_q.ent[fl_set][w].valid;
    end

    tlb_victim_sel i_victim (
        .valid   (fl_valid),
        .match   (fl_match),
        .ptr     (st_q.ptr[fl_set]),
        .way     (fl_way),
        .replace (fl_replace)
    );

    always_comb begin
        st_d = st_q;
        if (flush) begin
            for (int s = 0; s < SETS; s++) begin
                st_d.ptr[s] = '0;
                for (int w = 0; w < WAYS; w++) begin
                    st_d.ent[s][w].valid = 1'b0;
                end
            end
        end else if (fill_en) begin
            st_d.ent[fl_set][fl_way].valid = 1'b1;
            st_d.ent[fl_set][fl_way].tag   = fl_tag;
            st_d.ent[fl_set][fl_way].ppn   = fill_ppn;
            if (fl_replace) begin
                st_d.ptr[fl_set] = st_q.ptr[fl_set] + WAY_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a miss drives a zero address.
    a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0));
    // R3: the page offset passes through on a hit.
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
    // R9: nothing hits in the cycle after a flush.
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);
    // R7: a replacement moves that set's pointer on by one.
    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush && fl_replace) |=>
        (st_q.ptr[$past(fl_set)] == WAY_W'($past(st_q.ptr[fl_set]) + 1)));
    // R8: a matching fill leaves the pointer alone.
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush && fl_any) |=>
        (st_q.ptr[$past(fl_set)] == $past(st_q.ptr[fl_set])));
endmodule

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [11:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic [7:0]  fill_vpn = '0;
    logic [5:0]  fill_ppn = '0;
    logic        flush = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // reference model
    bit       m_v [4][4];
    bit [5:0] m_t [4][4];
    bit [5:0] m_p [4][4];
    bit [1:0] m_ptr [4];

    always #2 clk = ~clk;

    tlb_xlate i_tlb_xlate (
        .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
        .lk_paddr(lk_paddr), .fill_en(fill_en), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .flush(flush)
    );

    function automatic void model_clear();
        for (int s = 0; s < 4; s++) begin
            m_ptr[s] = 2'd0;
            for (int w = 0; w < 4; w++) m_v[s][w] = 1'b0;
        end
    endfunction

    function automatic void model_fill(bit [7:0] vpn, bit [5:0] ppn);
        int s = vpn[1:0];
        bit [5:0] t = vpn[7:2];
        int way = -1;
        for (int w = 0; w < 4; w++) if (m_v[s][w] && m_t[s][w] == t) way = w;
        if (way < 0) for (int w = 3; w >= 0; w--) if (!m_v[s][w]) way = w;
        if (way < 0) begin
            way = m_ptr[s];
            m_ptr[s] = m_ptr[s] + 2'd1;
        end
        m_v[s][way] = 1'b1;
        m_t[s][way] = t;
        m_p[s][way] = ppn;
    endfunction

    function automatic bit [12:0] model_look(bit [13:0] va);
        int s = va[7:6];
        for (int w = 0; w < 4; w++)
            if (m_v[s][w] && m_t[s][w] == va[13:8])
                return {1'b1, m_p[s][w], va[5:0]};
        return 13'd0;
    endfunction

    task automatic check(bit ok, string req, logic [12:0] act, logic [12:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(bit [13:0] va, string req);
        logic [12:0] exp;
        lk_vaddr = va;
        #1;
        exp = model_look(va);
        check({lk_hit, lk_paddr} === exp, req, {lk_hit, lk_paddr}, exp);
    endtask

    task automatic do_fill(bit [7:0] vpn, bit [5:0] ppn);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
        @(negedge clk);
        fill_en = 1'b0;
        model_fill(vpn, ppn);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        model_clear();
    endtask

    function automatic bit [13:0] va_of(bit [5:0] tag, bit [1:0] set, bit [5:0] off);
        return {tag, set, off};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: empty after reset
        look(va_of(6'h00, 2'd0, 6'h00), "R1 reset miss");
        look(va_of(6'h3F, 2'd3, 6'h3F), "R1 reset miss");

        // R6 / R2 / R3 / R4: four tags fit in set 1
        for (int k = 0; k < 4; k++) do_fill({6'(k + 1), 2'd1}, 6'(8'h10 + k));
        for (int k = 0; k < 4; k++) look(va_of(6'(k + 1), 2'd1, 6'(k * 9)), "R6 R3 fill resident");
        look(va_of(6'h02, 2'd1, 6'h2A), "R4 combinational change");
        look(va_of(6'h02, 2'd2, 6'h2A), "R2 other set miss R5");
        look(va_of(6'h05, 2'd1, 6'h01), "R5 miss zero");

        // R7: replacement order 0,1,2,3
        do_fill({6'h05, 2'd1}, 6'h21);
        look(va_of(6'h01, 2'd1, 6'h00), "R7 way0 evicted");
        look(va_of(6'h05, 2'd1, 6'h07), "R7 new tag hit");
        do_fill({6'h06, 2'd1}, 6'h22);
        look(va_of(6'h02, 2'd1, 6'h00), "R7 way1 evicted");
        look(va_of(6'h03, 2'd1, 6'h00), "R7 way2 kept");

        // R8: refill of resident tag
        do_fill({6'h03, 2'd1}, 6'h3C);
        look(va_of(6'h03, 2'd1, 6'h11), "R8 overwrite ppn");
        look(va_of(6'h04, 2'd1, 6'h11), "R8 neighbour kept");
        do_fill({6'h07, 2'd1}, 6'h23);
        look(va_of(6'h03, 2'd1, 6'h00), "R8 R7 pointer unchanged by overwrite");
        look(va_of(6'h04, 2'd1, 6'h00), "R7 way3 kept");

        // R10: other sets untouched
        do_fill({6'h09, 2'd2}, 6'h2B);
        look(va_of(6'h09, 2'd2, 6'h05), "R10 set2 hit");
        look(va_of(6'h06, 2'd1, 6'h05), "R10 set1 unchanged");
        look(va_of(6'h09, 2'd0, 6'h05), "R10 set0 still empty");

        // R9: flush wins over fill
        @(negedge clk);
        flush = 1'b1; fill_en = 1'b1; fill_vpn = {6'h0A, 2'd0}; fill_ppn = 6'h15;
        @(negedge clk);
        flush = 1'b0; fill_en = 1'b0;
        model_clear();
        look(va_of(6'h0A, 2'd0, 6'h00), "R9 fill dropped");
        look(va_of(6'h09, 2'd2, 6'h00), "R9 flushed");
        look(va_of(6'h06, 2'd1, 6'h00), "R9 flushed");
        // R9: pointer back to 0 after flush
        for (int k = 0; k < 5; k++) do_fill({6'(k + 20), 2'd3}, 6'(k));
        look(va_of(6'd20, 2'd3, 6'h00), "R9 R7 pointer reset");
        look(va_of(6'd21, 2'd3, 6'h00), "R9 R7 pointer reset");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 99);
            if (op < 2) begin
                do_flush();
            end else if (op < 45) begin
                do_fill({6'($urandom_range(0, 7)), 2'($urandom_range(0, 3))}, 6'($urandom));
            end else begin
                @(negedge clk);
                look({6'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 6'($urandom)},
                     "R3 R5 R6 R7 R8 random");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule